// File: doc/BRIEF.md
# Turn-Synchronised Memory Address Generator

This block drives the port-side address and a shared write enable for a group of monitor or playback memories. The host arms it by raising one bit of a control word. The generator then waits for the next begin-of-turn marker and counts up from address 0, one step per clock cycle, until it reaches a programmable top address.

How it stops depends on the host control bits. In single-pass mode it stops after one sweep. In repeat mode it keeps sweeping until the host drops the repeat bit, and then it finishes the sweep in progress. In save mode an external save-monitor pulse halts it at once, in the middle of a sweep. Whatever causes the stop, the address output freezes on the last location that was used, so the host can read back where the capture ended.

A separate control bit keeps the write enable low for the whole run. This lets the same address sweep replay memory contents without overwriting them.

Top module: `turn_ag`

## Requirements
- R1: A 0-to-1 change of control bit 0 arms the generator. The generator does not run until a later cycle in which `bot_i` is high, and `running_o` rises in the cycle after that cycle. Holding bit 0 high, or pulsing `bot_i` while not armed, never starts a run.
- R2: Every run starts with `addr_o` = 0 in its first running cycle.
- R3: While running, `addr_o` advances by one per cycle up to a top address equal to `len_i` + 1 (a wrap to zero is the only exception). A `len_i` of 1022 gives addresses 0 to 1023.
- R4: With control bit 1 = 0, the generator makes exactly one pass and stops after the cycle at the top address. `addr_o` then holds the top address.
- R5: With control bit 1 = 1, the generator wraps from the top address back to 0 and continues. Once bit 1 is cleared, it completes the current pass up to the top address and stops there.
- R6: With control bits 1 and 2 both set, a cycle in which `save_i` is high while running is the last running cycle. `addr_o` holds the address of that cycle.
- R7: With control bit 2 = 0, `save_i` has no effect on the run length or on the stop address.
- R8: With control bit 3 = 0, `wen_o` stays low throughout a run (playback). With bit 3 = 1, `wen_o` is high in every running cycle.
- R9: `wen_o` is never high while `running_o` is low, so both fall in the same cycle whatever the cause of the stop.
- R10: After reset, `addr_o` = 0 and `running_o` = `wen_o` = 0. While idle, `addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 4 | Host control: bit 0 arm, bit 1 repeat, bit 2 save-stop enable, bit 3 write enable allow |
| len_i | input | AW | Length value: top address minus one |
| bot_i | input | 1 | Begin-of-turn marker |
| save_i | input | 1 | Save-monitor stop request |
| addr_o | output | AW | Current address; holds the last used address when stopped |
| wen_o | output | 1 | Global write enable |
| running_o | output | 1 | Generator is running |

## Verification
The bench checks that a turn marker seen before arming is ignored. A design that started on it would not be turn-aligned. It also checks the release of repeat mode partway through a pass. A design that stopped at once, or that ran one extra pass, would show the wrong stop address and the wrong cycle count. A save pulse is applied both with save-stop enabled and with it disabled. A save path that was not gated would truncate the single-pass run. The bench also covers a length of 0 (a two-address sweep) and the full 1024-address sweep. Off-by-one errors in the top compare show up there as a stop address of 1022 or an extra cycle.

// File: rtl/turn_ag_pkg.sv
package turn_ag_pkg;
  typedef enum logic [1:0] {
    AG_IDLE  = 2'd0,
    AG_ARMED = 2'd1,
    AG_RUN   = 2'd2
  } ag_state_e;

  localparam int CB_ARM  = 0;
  localparam int CB_LOOP = 1;
  localparam int CB_SAVE = 2;
  localparam int CB_WEN  = 3;
  localparam int CTRL_W  = 4;
endpackage

// File: rtl/turn_ag_arm.sv
module turn_ag_arm (
  input  logic clk,
  input  logic rst,
  input  logic arm_bit,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= arm_bit;
  end

  assign rise_o = arm_bit & ~prev_q;
endmodule

// File: rtl/turn_ag_count.sv
module turn_ag_count #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [AW-1:0] top,
  output logic [AW-1:0] addr_o,
  output logic          at_top_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (clr) addr_q <= '0;
    else if (inc) addr_q <= addr_q + 1'b1;
  end

  assign addr_o   = addr_q;
  assign at_top_o = (addr_q == top);
endmodule

// File: rtl/turn_ag_fsm.sv
module turn_ag_fsm
  import turn_ag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm_rise,
  input  logic bot_i,
  input  logic loop_en,
  input  logic save_en,
  input  logic wen_en,
  input  logic save_i,
  input  logic at_top,
  output logic clr_o,
  output logic inc_o,
  output logic running_o,
  output logic wen_o
);
  ag_state_e state_q, state_d;
  logic      wen_q;
  logic      save_hit;

  assign save_hit = loop_en & save_en & save_i;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    case (state_q)
      AG_IDLE: begin
        if (arm_rise) state_d = AG_ARMED;
      end
      AG_ARMED: begin
        if (bot_i) begin
          state_d = AG_RUN;
          clr_o   = 1'b1;
        end
      end
      AG_RUN: begin
        if (save_hit) begin
          state_d = AG_IDLE;
        end else if (at_top) begin
          if (loop_en) clr_o   = 1'b1;
          else         state_d = AG_IDLE;
        end else begin
          inc_o = 1'b1;
        end
      end
      default: state_d = AG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= AG_IDLE;
      wen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wen_q   <= (state_d == AG_RUN) && wen_en;
    end
  end

  assign running_o = (state_q == AG_RUN);
  assign wen_o     = wen_q;
endmodule

// File: rtl/turn_ag.sv
module turn_ag
  import turn_ag_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [AW-1:0]     len_i,
  input  logic              bot_i,
  input  logic              save_i,
  output logic [AW-1:0]     addr_o,
  output logic              wen_o,
  output logic              running_o
);
  logic          arm_rise;
  logic          clr, inc, at_top;
  logic [AW-1:0] top_addr;

  assign top_addr = len_i + 1'b1;

  turn_ag_arm u_arm (
    .clk     (clk),
    .rst     (rst),
    .arm_bit (ctrl_i[CB_ARM]),
    .rise_o  (arm_rise)
  );

  turn_ag_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .arm_rise  (arm_rise),
    .bot_i     (bot_i),
    .loop_en   (ctrl_i[CB_LOOP]),
    .save_en   (ctrl_i[CB_SAVE]),
    .wen_en    (ctrl_i[CB_WEN]),
    .save_i    (save_i),
    .at_top    (at_top),
    .clr_o     (clr),
    .inc_o     (inc),
    .running_o (running_o),
    .wen_o     (wen_o)
  );

  turn_ag_count #(.AW(AW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .inc      (inc),
    .top      (top_addr),
    .addr_o   (addr_o),
    .at_top_o (at_top)
  );
endmodule

// File: rtl/turn_ag_chk.sv
module turn_ag_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          loop_en,
  input logic          save_en,
  input logic          wen_en,
  input logic          bot_i,
  input logic          save_i,
  input logic [AW-1:0] addr_o,
  input logic          wen_o,
  input logic          running_o
);
  AST_START_ON_TURN: assert property (@(posedge clk) disable iff (rst)
    $rose(running_o) |-> $past(bot_i)); // R1
  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(running_o) |-> (addr_o == '0)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (running_o && $past(running_o) && addr_o != '0) |-> (addr_o == AW'($past(addr_o) + 1'b1))); // R3
  AST_SAVE_HALT: assert property (@(posedge clk) disable iff (rst)
    (running_o && loop_en && save_en && save_i) |=> !running_o); // R6
  AST_PLAYBACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wen_en |=> !wen_o); // R8
  AST_WEN_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    wen_o |-> running_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !$past(running_o)) |-> $stable(addr_o)); // R10
endmodule

bind turn_ag turn_ag_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .loop_en   (ctrl_i[1]),
  .save_en   (ctrl_i[2]),
  .wen_en    (ctrl_i[3]),
  .bot_i     (bot_i),
  .save_i    (save_i),
  .addr_o    (addr_o),
  .wen_o     (wen_o),
  .running_o (running_o)
);

// File: tb/turn_ag_test.sv
`timescale 1ns/1ps
module turn_ag_test;
  localparam int AW = 10;

  typedef struct packed {
    logic        loop;
    logic        saveen;
    logic        wenen;
    logic [15:0] len;
    int          save_n;
    int          rel_n;
    int          cycles;
    int          stop;
  } case_t;

  localparam int NCASE = 8;
  localparam case_t CASES [NCASE] = '{
    '{1'b0, 1'b0, 1'b1, 16'd4,    -1, -1, 6,    5},    // R4 single pass
    '{1'b0, 1'b0, 1'b0, 16'd4,    -1, -1, 6,    5},    // R8 playback
    '{1'b1, 1'b0, 1'b1, 16'd2,    -1,  9, 12,   3},    // R5 release mid pass
    '{1'b1, 1'b1, 1'b1, 16'd6,    10, -1, 11,   2},    // R6 save stop
    '{1'b0, 1'b0, 1'b1, 16'd4,     2, -1, 6,    5},    // R7 save ignored
    '{1'b0, 1'b0, 1'b1, 16'd0,    -1, -1, 2,    1},    // R3 shortest
    '{1'b1, 1'b1, 1'b1, 16'd2,    -1,  5, 8,    3},    // R5 clear both bits
    '{1'b0, 1'b0, 1'b1, 16'd1022, -1, -1, 1024, 1023}  // R3 full sweep
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    ctrl_i;
  logic [AW-1:0] len_i;
  logic          bot_i, save_i;
  logic [AW-1:0] addr_o;
  logic          wen_o, running_o;
  int            errors = 0;
  int            checks = 0;

  always #2.5 clk = ~clk;

  turn_ag #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .ctrl_i(ctrl_i), .len_i(len_i),
    .bot_i(bot_i), .save_i(save_i),
    .addr_o(addr_o), .wen_o(wen_o), .running_o(running_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input case_t c);
    int  n;
    int  span;
    bit  seq_ok, wen_ok;
    int  bad_addr, bad_exp;
    span = int'(c.len) + 2;
    ctrl_i = {c.wenen, c.saveen, c.loop, 1'b0};
    len_i  = c.len[AW-1:0];
    repeat (2) @(negedge clk);
    ctrl_i[0] = 1'b1;
    repeat (3) @(negedge clk);
    check(running_o == 1'b0, "R1 idle while armed", int'(running_o), 0);
    bot_i = 1'b1;
    @(negedge clk);
    bot_i = 1'b0;
    n = 0; seq_ok = 1'b1; wen_ok = 1'b1; bad_addr = 0; bad_exp = 0;
    while (running_o && n < 5000) begin
      if (seq_ok && int'(addr_o) != n % span) begin
        seq_ok = 1'b0; bad_addr = int'(addr_o); bad_exp = n % span;
      end
      if (wen_o != c.wenen) wen_ok = 1'b0;
      save_i = (n == c.save_n);
      if (n == c.rel_n) begin
        ctrl_i[1] = 1'b0;
        ctrl_i[2] = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    save_i = 1'b0;
    check(seq_ok, "R2/R3 address sequence", bad_addr, bad_exp);
    check(wen_ok, "R8 write enable during run", int'(wen_o), int'(c.wenen));
    check(n == c.cycles, "R4/R5/R6/R7 run length", n, c.cycles);
    check(int'(addr_o) == c.stop, "R10 stop address held", int'(addr_o), c.stop);
    check(wen_o == 1'b0, "R9 wen low at stop", int'(wen_o), 0);
    repeat (3) @(negedge clk);
    check(int'(addr_o) == c.stop && !running_o, "R10 idle hold", int'(addr_o), c.stop);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; ctrl_i = '0; len_i = '0; bot_i = 1'b0; save_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(addr_o == '0, "R10 reset addr", int'(addr_o), 0);
    check(!running_o, "R10 reset running", int'(running_o), 0);
    check(!wen_o, "R10 reset wen", int'(wen_o), 0);
    // R1 turn marker without arming
    len_i = 10'd4; ctrl_i = 4'b1000;
    bot_i = 1'b1; @(negedge clk); bot_i = 1'b0;
    repeat (2) @(negedge clk);
    check(!running_o, "R1 marker before arming", int'(running_o), 0);

    for (int i = 0; i < NCASE; i++) run_case(CASES[i]);

    // R1 arm bit left high: a new marker must not restart
    bot_i = 1'b1; @(negedge clk); bot_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!running_o, "R1 no restart without new rise", int'(running_o), 0);
    check(!wen_o, "R9 wen stays low when idle", int'(wen_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule